// File: doc/BRIEF.md
# Receive polarity detect and correct

This block sits in the receive path of a 10 Mb/s twisted-pair receiver. It works out whether the wire pair is connected with the two conductors swapped, which inverts the signal, and undoes the inversion. The front end has already qualified the line events and presents them as single-cycle strobes. The strobes are link pulses and end-of-frame markers, each tagged as normal or inverted. There is also a generic activity strobe and a slow timebase tick. The block drives an invert control that the data path XORs onto each received bit. It also pulses a receive error for every frame that arrives with the wrong polarity before the correction takes effect.

The decision is always made relative to the correction already applied. Once the invert control is set, a strobe tagged "normal" counts as wrong-polarity. Link pulses and frame markers each keep their own run counter of consecutive wrong-polarity events. Either counter reaching its threshold flips the correction. A long quiet period drops the correction back to non-inverted.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset `invert_o` is 0 and `rx_err_o` is 0.
- R2: A run of PULSE_RUN (default 8) consecutive wrong-polarity link pulses toggles `invert_o` on the clock edge that samples the last pulse of the run. A run one shorter leaves `invert_o` unchanged.
- R3: A run of FRAME_RUN (default 4) consecutive wrong-polarity end-of-frame markers toggles `invert_o` on the clock edge that samples the last marker. A run one shorter leaves `invert_o` unchanged.
- R4: A correct-polarity link pulse restarts the link-pulse run and a correct-polarity frame marker restarts the frame run. Events of one type never alter the run of the other type.
- R5: Polarity is judged after correction. While `invert_o`=0, strobes on `lp_inv_i`/`eof_inv_i` are wrong and strobes on `lp_norm_i`/`eof_norm_i` are correct. While `invert_o`=1 the roles swap.
- R6: Each toggle of `invert_o` restarts both runs, so after a toggle a full new run of either type is needed to toggle again.
- R7: Every wrong-polarity frame marker, including the one that completes a run, makes `rx_err_o` high for exactly one cycle, starting with the clock edge that samples it. Correct-polarity markers and link pulses never raise `rx_err_o`.
- R8: If TIMEOUT_TICKS timebase ticks arrive with no activity, `invert_o` returns to 0 on the edge that samples the last tick, and both runs restart. Activity means `activity_i` or any event strobe, and it restarts the tick count.
- R9: When both runs complete in the same cycle, `invert_o` toggles once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_norm_i | input | 1 | Link pulse seen with normal shape (raw, before correction) |
| lp_inv_i | input | 1 | Link pulse seen with inverted shape (raw) |
| eof_norm_i | input | 1 | End-of-frame marker seen with normal shape (raw) |
| eof_inv_i | input | 1 | End-of-frame marker seen with inverted shape (raw) |
| activity_i | input | 1 | Any receive activity; restarts the quiet timer |
| tick_i | input | 1 | Timebase tick for the quiet timer |
| invert_o | output | 1 | Polarity correction; XOR onto the received data bit |
| rx_err_o | output | 1 | One-cycle error per wrong-polarity frame end |

## Verification
From reset, runs of wrong link pulses from 0 to 10 long and runs of wrong frame markers from 0 to 6 long are swept. They place the threshold exactly and show how many error pulses occur for each run length. Runs broken by a single correct event at every position separate a consecutive count from a total count. Mixing event types shows that the two counters are independent. After a switch, raw "normal" strobes are replayed to show that polarity is judged after correction and that both runs restart on a toggle. Quiet periods one tick short of and exactly at the timeout separate the timeout boundary. A period broken by activity shows that activity restarts the count. Both runs completing in the same cycle separates a single toggle from a double toggle.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  // event judged relative to the current correction
  typedef struct packed {
    logic bad;
    logic good;
  } rel_evt_t;

  localparam int unsigned NUM_KINDS  = 2;
  localparam int unsigned KIND_PULSE = 0;
  localparam int unsigned KIND_FRAME = 1;
endpackage

// File: rtl/rpc_orient.sv
module rpc_orient
  import rpc_pkg::*;
(
  input  logic     invert_i,
  input  logic     raw_norm_i,
  input  logic     raw_inv_i,
  output rel_evt_t evt_o
);
  always_comb begin
    evt_o.bad  = invert_i ? raw_norm_i : raw_inv_i;
    evt_o.good = invert_i ? raw_inv_i  : raw_norm_i;
  end
endmodule

// File: rtl/rpc_streak.sv
module rpc_streak
  import rpc_pkg::*;
#(
  parameter int unsigned RUN = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  rel_evt_t evt_i,
  output logic     hit_o
);
  localparam int unsigned W = $clog2(RUN + 1);
  localparam logic [W-1:0] LAST = W'(RUN - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = evt_i.bad && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (evt_i.bad) cnt_q <= cnt_q + 1'b1;
    else if (evt_i.good) cnt_q <= '0;
  end

  p_run_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(RUN));
  p_hit_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (cnt_q == '0));
endmodule

// File: rtl/rpc_timeout.sv
module rpc_timeout #(
  parameter int unsigned LIMIT = 150_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic act_i,
  output logic fire_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign fire_o = tick_i && !act_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (act_i || fire_o)   cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  p_act_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (cnt_q == '0));
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(LIMIT));
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix
  import rpc_pkg::*;
#(
  parameter int unsigned PULSE_RUN     = 8,
  parameter int unsigned FRAME_RUN     = 4,
  parameter int unsigned TIMEOUT_TICKS = 150_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_norm_i,
  input  logic lp_inv_i,
  input  logic eof_norm_i,
  input  logic eof_inv_i,
  input  logic activity_i,
  input  logic tick_i,
  output logic invert_o,
  output logic rx_err_o
);
  logic                 invert_q, err_q;
  logic [NUM_KINDS-1:0] raw_norm, raw_inv, hit;
  rel_evt_t             evt [NUM_KINDS];
  logic                 declare, timeout, act;

  assign raw_norm = {eof_norm_i, lp_norm_i};
  assign raw_inv  = {eof_inv_i, lp_inv_i};
  assign declare  = |hit;
  assign act      = activity_i | (|raw_norm) | (|raw_inv);

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    localparam int unsigned RUN_K = (k == KIND_PULSE) ? PULSE_RUN : FRAME_RUN;

    rpc_orient u_orient (
      .invert_i  (invert_q),
      .raw_norm_i(raw_norm[k]),
      .raw_inv_i (raw_inv[k]),
      .evt_o     (evt[k])
    );

    rpc_streak #(.RUN(RUN_K)) u_streak (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (declare | timeout),
      .evt_i (evt[k]),
      .hit_o (hit[k])
    );
  end

  rpc_timeout #(.LIMIT(TIMEOUT_TICKS)) u_timeout (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .act_i (act),
    .fire_o(timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      invert_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= evt[KIND_FRAME].bad;
      if (timeout)      invert_q <= 1'b0;
      else if (declare) invert_q <= ~invert_q;
    end
  end

  assign invert_o = invert_q;
  assign rx_err_o = err_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!declare && !timeout) |=> $stable(invert_o));
  p_single_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    declare |=> (invert_o != $past(invert_o)));
  p_timeout_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> !invert_o);
  p_err_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> $past(eof_inv_i || eof_norm_i));
  p_no_timeout_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> !timeout);
endmodule

// File: tb/sim_rx_polarity_fix.sv
module sim_rx_polarity_fix;
  localparam int unsigned TMO = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lp_n = 0, lp_i = 0, eof_n = 0, eof_i = 0, act = 0, tick = 0;
  logic inv, err;
  int total = 0, bad = 0, errs = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  rx_polarity_fix #(.PULSE_RUN(8), .FRAME_RUN(4), .TIMEOUT_TICKS(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lp_norm_i(lp_n), .lp_inv_i(lp_i),
    .eof_norm_i(eof_n), .eof_inv_i(eof_i), .activity_i(act), .tick_i(tick),
    .invert_o(inv), .rx_err_o(err));

  always @(negedge clk) if (err) errs++;

  task automatic chk(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    errs = 0;
  endtask

  // m = {lp_norm, lp_inv, eof_norm, eof_inv}
  task automatic ev(input logic [3:0] m);
    {lp_n, lp_i, eof_n, eof_i} = m;
    @(negedge clk);
    {lp_n, lp_i, eof_n, eof_i} = 4'b0;
    @(negedge clk);
  endtask

  task automatic ev_n(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) ev(m);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  localparam logic [3:0] LPN = 4'b1000, LPI = 4'b0100, EFN = 4'b0010, EFI = 4'b0001;

  initial begin
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 invert in reset", int'(inv), 0);
    chk("R1 err in reset", int'(err), 0);
    do_reset();
    chk("R1 invert after reset", int'(inv), 0);

    // R2 sweep of pulse run length
    for (int n = 0; n <= 10; n++) begin
      do_reset();
      ev_n(LPI, n);
      chk($sformatf("R2 pulses n=%0d", n), int'(inv), (n >= 8) ? 1 : 0);
      chk($sformatf("R7 no err from pulses n=%0d", n), errs, 0);
    end

    // R3/R7 sweep of frame run length
    for (int n = 0; n <= 6; n++) begin
      do_reset();
      ev_n(EFI, n);
      chk($sformatf("R3 frames n=%0d", n), int'(inv), (n >= 4) ? 1 : 0);
      chk($sformatf("R7 err count n=%0d", n), errs, (n < 4) ? n : 4);
    end

    // R4 broken runs
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      ev_n(LPI, k); ev(LPN); ev_n(LPI, 7);
      chk($sformatf("R4 pulse run broken at %0d", k), int'(inv), 0);
      ev(LPI);
      chk($sformatf("R4 pulse run resumes k=%0d", k), int'(inv), 1);
    end
    for (int k = 1; k <= 3; k++) begin
      do_reset();
      ev_n(EFI, k); ev(EFN); ev_n(EFI, 3);
      chk($sformatf("R4 frame run broken at %0d", k), int'(inv), 0);
      chk($sformatf("R7 correct eof no err k=%0d", k), errs, k + 3);
    end
    do_reset();
    ev_n(EFI, 3); ev_n(LPN, 5); ev(EFI);
    chk("R4 pulses leave frame run", int'(inv), 1);
    do_reset();
    ev_n(LPI, 7); ev_n(EFN, 3); ev(LPI);
    chk("R4 frames leave pulse run", int'(inv), 1);

    // R5 judged after correction
    do_reset();
    ev_n(LPI, 8);
    ev_n(LPN, 7);
    chk("R5 seven raw normal pulses while inverted", int'(inv), 1);
    ev(LPN);
    chk("R5 eighth raw normal pulse reverts", int'(inv), 0);
    do_reset();
    ev_n(EFI, 4); errs = 0;
    ev_n(EFI, 2);
    chk("R5 raw inv eof correct while inverted", errs, 0);
    ev(EFN);
    chk("R5 raw norm eof wrong while inverted", errs, 1);

    // R6 toggle restarts both runs
    do_reset();
    ev_n(EFI, 3); ev_n(LPI, 8);
    chk("R6 switch by pulses", int'(inv), 1);
    errs = 0;
    ev(EFN);
    chk("R6 frame run restarted", int'(inv), 1);
    chk("R7 err after switch", errs, 1);
    ev_n(LPN, 6);
    chk("R6 pulse run restarted", int'(inv), 1);

    // R8 timeout
    do_reset();
    ev_n(LPI, 8);
    ticks(TMO - 1);
    chk("R8 one tick short", int'(inv), 1);
    ticks(1);
    chk("R8 timeout reverts", int'(inv), 0);
    do_reset();
    ev_n(LPI, 8);
    ticks(TMO - 1);
    act = 1'b1; @(negedge clk); act = 1'b0; @(negedge clk);
    ticks(TMO - 1);
    chk("R8 activity restarts", int'(inv), 1);
    ticks(1);
    chk("R8 timeout after restart", int'(inv), 0);
    do_reset();
    ev_n(LPI, 7); ticks(TMO); ev(LPI);
    chk("R8 timeout clears pulse run", int'(inv), 0);
    do_reset();
    ev_n(EFI, 3); ticks(TMO); errs = 0; ev(EFI);
    chk("R8 timeout clears frame run", int'(inv), 0);

    // R9 simultaneous completion
    do_reset();
    ev_n(LPI, 7); ev_n(EFI, 3); errs = 0;
    ev(LPI | EFI);
    chk("R9 single toggle", int'(inv), 1);
    chk("R7 err on completing eof", errs, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule